// File: doc/BRIEF.md
# Omega Switching Network

This block is a pipelined multistage interconnect that joins P source ports to P destination ports, with P a power of two (8 by default). It is made of AW = log2(P) stages. Ahead of each stage the lanes are reordered by a perfect shuffle. The stage then pairs adjacent lanes into P/2 two-by-two switching elements. Each element is set either straight or crossed. The setting is found by comparing one bit of the source label with one bit of the destination label, taking one bit per stage from the most significant end.

Every cycle each source port may present a request: a valid flag, a destination index and a payload. The source label is the port index. The network is blocking, so two requests may need the same internal link. It does not resolve such conflicts by buffering or retry. Inside a switch the request from the lower-numbered source keeps the link. The other request is dropped, and this is reported on a per-source blocked flag. That flag appears in the same cycle the request would have been delivered. Every stage is registered, so a new request set can enter on every cycle.

Top module: `omega_network`

## Requirements
- R1: A request entering on a clock edge appears at its destination port after AW = log2(P) clock edges, and its valid flag travels with it.
- R2: A request that is not blocked is delivered on output port out_data[d*W +: W] with out_valid[d] high, where d is the destination index in in_dest[s*AW +: AW] and the payload comes from in_data[s*W +: W]. The payload is unchanged.
- R3: When two surviving requests need the same switch output, the request with the lower source index keeps it. The other request is dropped and its payload is delivered nowhere.
- R4: out_blocked[s] rises in the cycle that request s would have been delivered, exactly when it loses a conflict. After stage k (k = 0 first) a request from s to d occupies lane ((s << (k+1)) | (d >> (AW-1-k))) mod P. Two requests still alive that land on the same lane collide. Requests dropped at earlier stages take no further part.
- R5: An output port that receives no request shows out_valid low and all-zero out_data.
- R6: While rst_n is low, out_valid and out_blocked are zero and all requests in flight are discarded.
- R7: An input with its valid flag low delivers nothing and raises no blocked flag. It also never competes with, or blocks, a valid request that shares a switch with it.
- R8: A uniform shift permutation, with every port valid and d = (s + c) mod P, is delivered in full with no blocked flag.
- R9: A new, independent request set is accepted on every cycle, and each set produces its own results AW cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | P | Per-source request flag |
| in_dest | input | P*AW | Destination index of source s in bits [s*AW +: AW] |
| in_data | input | P*W | Payload of source s in bits [s*W +: W] |
| out_valid | output | P | Delivery flag per destination port |
| out_data | output | P*W | Payload at destination d in bits [d*W +: W], zero when idle |
| out_blocked | output | P | Per-source flag: the request from s was dropped |

## Verification
The bench targets a hot spot where every source names destination 0; only source 0 may get through. A priority rule that is reversed or missing would deliver the wrong payload or flag the wrong source. It also targets a lone valid request whose switch partner is invalid but carries the same destination. A design that let invalid lanes compete would drop or flag that request. Bit reversal and random permutations set the flags against an independent lane-position model, so a wrong shuffle direction or wrong stage bit order shows up as misrouted data or wrong flags. Uniform shifts, a reset in mid-stream and a latency probe expose a lost pipeline register or leftover traffic in flight.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic {
        SW_STRAIGHT = 1'b0,
        SW_CROSS    = 1'b1
    } sw_mode_e;

    // Perfect-shuffle lane mapping: rotate the lane index left by one bit.
    function automatic int unsigned shuffle_idx(input int unsigned idx, input int unsigned nbits);
        int unsigned mask;
        mask = (32'd1 << nbits) - 32'd1;
        return ((idx << 1) | (idx >> (nbits - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          a_vld,
    input  logic          a_bit,
    input  logic [AW-1:0] a_src,
    input  logic          b_vld,
    input  logic          b_bit,
    input  logic [AW-1:0] b_src,
    output sw_mode_e      mode_o,
    output logic          a_keep,
    output logic          b_keep
);

    logic clash;
    logic a_first;

    always_comb begin
        clash   = a_vld && b_vld && (a_bit == b_bit);
        a_first = (a_src < b_src);
        a_keep  = a_vld && !(clash && !a_first);
        b_keep  = b_vld && !(clash && a_first);
        if (a_keep) begin
            mode_o = a_bit ? SW_CROSS : SW_STRAIGHT;
        end else if (b_keep) begin
            mode_o = b_bit ? SW_STRAIGHT : SW_CROSS;
        end else begin
            mode_o = SW_STRAIGHT;
        end
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int P     = 8,
    parameter int AW    = 3,
    parameter int W     = 8,
    parameter int STAGE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [P-1:0]         in_vld,
    input  logic [P-1:0][AW-1:0] in_dst,
    input  logic [P-1:0][AW-1:0] in_src,
    input  logic [P-1:0][W-1:0]  in_dat,
    input  logic [P-1:0]         in_blk,
    output logic [P-1:0]         out_vld,
    output logic [P-1:0][AW-1:0] out_dst,
    output logic [P-1:0][AW-1:0] out_src,
    output logic [P-1:0][W-1:0]  out_dat,
    output logic [P-1:0]         out_blk
);

    localparam int NSW = P / 2;
    localparam int SEL = AW - 1 - STAGE;

    typedef struct packed {
        logic [P-1:0]         vld;
        logic [P-1:0][AW-1:0] dst;
        logic [P-1:0][AW-1:0] src;
        logic [P-1:0][W-1:0]  dat;
        logic [P-1:0]         blk;
    } stage_t;

    logic [P-1:0]         sh_vld;
    logic [P-1:0][AW-1:0] sh_dst;
    logic [P-1:0][AW-1:0] sh_src;
    logic [P-1:0][W-1:0]  sh_dat;
    sw_mode_e             mode [NSW];
    logic [P-1:0]         keep;
    stage_t               st_d;
    stage_t               st_q;

    always_comb begin : shuffle
        logic [AW-1:0] pos;
        sh_vld = '0;
        sh_dst = '0;
        sh_src = '0;
        sh_dat = '0;
        for (int i = 0; i < P; i++) begin
            pos         = AW'(shuffle_idx(i, AW));
            sh_vld[pos] = in_vld[i];
            sh_dst[pos] = in_dst[i];
            sh_src[pos] = in_src[i];
            sh_dat[pos] = in_dat[i];
        end
    end

    for (genvar j = 0; j < NSW; j++) begin : g_sw
        omega_switch #(.AW(AW)) u_sw (
            .a_vld  (sh_vld[2*j]),
            .a_bit  (sh_dst[2*j][SEL]),
            .a_src  (sh_src[2*j]),
            .b_vld  (sh_vld[2*j+1]),
            .b_bit  (sh_dst[2*j+1][SEL]),
            .b_src  (sh_src[2*j+1]),
            .mode_o (mode[j]),
            .a_keep (keep[2*j]),
            .b_keep (keep[2*j+1])
        );
    end

    always_comb begin : next_state
        int up;
        int dn;
        st_d     = '0;
        st_d.blk = in_blk;
        for (int j = 0; j < NSW; j++) begin
            up = (mode[j] == SW_STRAIGHT) ? 2*j     : 2*j + 1;
            dn = (mode[j] == SW_STRAIGHT) ? 2*j + 1 : 2*j;
            st_d.vld[2*j]   = keep[up];
            st_d.dst[2*j]   = sh_dst[up];
            st_d.src[2*j]   = sh_src[up];
            st_d.dat[2*j]   = keep[up] ? sh_dat[up] : '0;
            st_d.vld[2*j+1] = keep[dn];
            st_d.dst[2*j+1] = sh_dst[dn];
            st_d.src[2*j+1] = sh_src[dn];
            st_d.dat[2*j+1] = keep[dn] ? sh_dat[dn] : '0;
        end
        for (int i = 0; i < P; i++) begin
            if (sh_vld[i] && !keep[i]) begin
                st_d.blk[sh_src[i]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_dst = st_q.dst;
    assign out_src = st_q.src;
    assign out_dat = st_q.dat;
    assign out_blk = st_q.blk;

endmodule

// File: rtl/omega_network.sv
module omega_network #(
    parameter int P = 8,
    parameter int W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [P-1:0]             in_valid,
    input  logic [P*$clog2(P)-1:0]   in_dest,
    input  logic [P*W-1:0]           in_data,
    output logic [P-1:0]             out_valid,
    output logic [P*W-1:0]           out_data,
    output logic [P-1:0]             out_blocked
);

    localparam int AW = $clog2(P);

    logic [P-1:0][AW-1:0]          dst0;
    logic [P-1:0][AW-1:0]          src0;
    logic [P-1:0][W-1:0]           dat0;

    logic [AW-1:0][P-1:0]          ch_vld;
    logic [AW-1:0][P-1:0][AW-1:0]  ch_dst;
    logic [AW-1:0][P-1:0][AW-1:0]  ch_src;
    logic [AW-1:0][P-1:0][W-1:0]   ch_dat;
    logic [AW-1:0][P-1:0]          ch_blk;

    assign dst0 = in_dest;
    assign dat0 = in_data;

    always_comb begin : label_sources
        for (int i = 0; i < P; i++) begin
            src0[i] = AW'(i);
        end
    end

    for (genvar k = 0; k < AW; k++) begin : g_stage
        logic [P-1:0]         i_vld;
        logic [P-1:0][AW-1:0] i_dst;
        logic [P-1:0][AW-1:0] i_src;
        logic [P-1:0][W-1:0]  i_dat;
        logic [P-1:0]         i_blk;

        if (k == 0) begin : g_head
            assign i_vld = in_valid;
            assign i_dst = dst0;
            assign i_src = src0;
            assign i_dat = dat0;
            assign i_blk = '0;
        end else begin : g_link
            assign i_vld = ch_vld[k-1];
            assign i_dst = ch_dst[k-1];
            assign i_src = ch_src[k-1];
            assign i_dat = ch_dat[k-1];
            assign i_blk = ch_blk[k-1];
        end

        omega_stage #(
            .P     (P),
            .AW    (AW),
            .W     (W),
            .STAGE (k)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (i_vld),
            .in_dst  (i_dst),
            .in_src  (i_src),
            .in_dat  (i_dat),
            .in_blk  (i_blk),
            .out_vld (ch_vld[k]),
            .out_dst (ch_dst[k]),
            .out_src (ch_src[k]),
            .out_dat (ch_dat[k]),
            .out_blk (ch_blk[k])
        );
    end

    assign out_valid   = ch_vld[AW-1];
    assign out_data    = ch_dat[AW-1];
    assign out_blocked = ch_blk[AW-1];

endmodule

// File: rtl/omega_network_chk.sv
module omega_network_chk #(
    parameter int P  = 8,
    parameter int W  = 8,
    parameter int AW = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [P-1:0]         in_valid,
    input logic [P-1:0]         out_valid,
    input logic [P*W-1:0]       out_data,
    input logic [P-1:0]         out_blocked,
    input logic [P-1:0][AW-1:0] fin_dst,
    input logic [P-1:0][AW-1:0] fin_src
);

    logic [AW-1:0][P-1:0] vpipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpipe <= '0;
        end else begin
            vpipe[0] <= in_valid;
            for (int k = 1; k < AW; k++) begin
                vpipe[k] <= vpipe[k-1];
            end
        end
    end

    a_r6_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_valid == '0 && out_blocked == '0));

    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_valid) + $countones(out_blocked)) == $countones(vpipe[AW-1]));

    a_r7_flag_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (out_blocked & ~vpipe[AW-1]) == '0);

    a_r4_lone_request_passes: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(vpipe[AW-1]) == 1) |-> (out_blocked == '0));

    for (genvar i = 0; i < P; i++) begin : g_port
        a_r2_lands_on_dest: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[i] |-> (fin_dst[i] == AW'(i)));

        a_r4_winner_unflagged: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[i] |-> !out_blocked[fin_src[i]]);

        a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[i] |-> (out_data[i*W +: W] == '0));
    end

endmodule

bind omega_network omega_network_chk #(
    .P  (P),
    .W  (W),
    .AW (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_blocked (out_blocked),
    .fin_dst     (ch_dst[AW-1]),
    .fin_src     (ch_src[AW-1])
);

// File: tb/omega_network_tb_top.sv
module omega_network_tb_top;

    localparam int P  = 8;
    localparam int W  = 8;
    localparam int AW = 3;
    localparam int NV = 12;
    localparam int NR = 40;
    localparam int NT = NV + NR;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [P-1:0]     in_valid;
    logic [P*AW-1:0]  in_dest;
    logic [P*W-1:0]   in_data;
    logic [P-1:0]     out_valid;
    logic [P*W-1:0]   out_data;
    logic [P-1:0]     out_blocked;

    always #5 clk = ~clk;

    omega_network #(.P(P), .W(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_dest     (in_dest),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_blocked (out_blocked)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // {valid mask, dest of port 7 ... dest of port 0}
    localparam logic [31:0] VEC [NV] = '{
        {8'hFF, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
        {8'hFF, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1},
        {8'hFF, 3'd7, 3'd3, 3'd5, 3'd1, 3'd6, 3'd2, 3'd4, 3'd0},
        {8'hFF, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        {8'h0A, 3'd0, 3'd0, 3'd0, 3'd0, 3'd5, 3'd0, 3'd5, 3'd0},
        {8'h40, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        {8'h01, 3'd0, 3'd0, 3'd0, 3'd3, 3'd0, 3'd0, 3'd0, 3'd3},
        {8'hFF, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7},
        {8'h00, 24'h0},
        {8'hFF, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3},
        {8'h55, 3'd0, 3'd2, 3'd0, 3'd7, 3'd0, 3'd2, 3'd0, 3'd5},
        {8'hFF, 3'd6, 3'd7, 3'd4, 3'd5, 3'd2, 3'd3, 3'd0, 3'd1}
    };

    logic [P-1:0]         sv_vld [NT];
    logic [P-1:0][AW-1:0] sv_dst [NT];

    function automatic logic [W-1:0] pay(input int tag, input int s);
        return W'(tag * 29 + s * 7 + 3);
    endfunction

    function automatic int lane(input int s, input int d, input int k);
        return ((s << (k + 1)) | (d >> (AW - 1 - k))) & (P - 1);
    endfunction

    function automatic logic [P-1:0] blocked_of(input logic [P-1:0] v, input logic [P-1:0][AW-1:0] d);
        logic [P-1:0] alive;
        logic [P-1:0] lost;
        logic [P-1:0] kill;
        alive = v;
        lost  = '0;
        for (int k = 0; k < AW; k++) begin
            kill = '0;
            for (int s = 1; s < P; s++) begin
                for (int t = 0; t < s; t++) begin
                    if (alive[s] && alive[t] && lane(s, int'(d[s]), k) == lane(t, int'(d[t]), k))
                        kill[s] = 1'b1;
                end
            end
            alive = alive & ~kill;
            lost  = lost | kill;
        end
        return lost;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [P-1:0] v, input logic [P-1:0][AW-1:0] d, input int tag);
        in_valid = v;
        in_dest  = d;
        for (int s = 0; s < P; s++) in_data[s*W +: W] = pay(tag, s);
    endtask

    task automatic idle();
        in_valid = '0;
        in_dest  = '0;
        in_data  = '0;
    endtask

    task automatic expect_of(input logic [P-1:0] v, input logic [P-1:0][AW-1:0] d, input int tag,
                             output logic [P-1:0] ev, output logic [P*W-1:0] ed, output logic [P-1:0] eb);
        eb = blocked_of(v, d);
        ev = '0;
        ed = '0;
        for (int s = 0; s < P; s++) begin
            if (v[s] && !eb[s]) begin
                ev[d[s]] = 1'b1;
                ed[int'(d[s])*W +: W] = pay(tag, s);
            end
        end
    endtask

    task automatic check_set(input int i);
        logic [P-1:0]   ev;
        logic [P*W-1:0] ed;
        logic [P-1:0]   eb;
        expect_of(sv_vld[i], sv_dst[i], i, ev, ed, eb);
        check("R9 R5", $sformatf("set %0d out_valid", i), out_valid, ev);
        check("R2", $sformatf("set %0d out_data", i), out_data, ed);
        check("R4", $sformatf("set %0d out_blocked", i), out_blocked, eb);
    endtask

    task automatic run_one(input logic [P-1:0] v, input logic [P-1:0][AW-1:0] d, input int tag,
                           output logic [P-1:0] ov, output logic [P*W-1:0] od, output logic [P-1:0] ob);
        @(negedge clk);
        drive(v, d, tag);
        @(negedge clk);
        idle();
        repeat (AW - 1) @(negedge clk);
        ov = out_valid;
        od = out_data;
        ob = out_blocked;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [P-1:0]         ov;
        logic [P*W-1:0]       od;
        logic [P-1:0]         ob;
        logic [P-1:0][AW-1:0] dd;
        idle();

        for (int i = 0; i < NV; i++) begin
            sv_vld[i] = VEC[i][31:24];
            sv_dst[i] = VEC[i][23:0];
        end
        for (int i = NV; i < NT; i++) begin
            int perm [P];
            for (int s = 0; s < P; s++) perm[s] = s;
            for (int s = P - 1; s > 0; s--) begin
                int j;
                int tmp;
                j = int'($urandom_range(s, 0));
                tmp = perm[s];
                perm[s] = perm[j];
                perm[j] = tmp;
            end
            for (int s = 0; s < P; s++) sv_dst[i][s] = AW'(perm[s]);
            sv_vld[i] = (i % 2 == 1) ? {P{1'b1}} : P'($urandom);
        end

        // R6: outputs quiet during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6", "out_valid in reset", out_valid, '0);
        check("R6", "out_blocked in reset", out_blocked, '0);
        check("R6", "out_data in reset", out_data, '0);
        rst_n = 1'b1;

        // R9: back-to-back stream of table and random sets
        for (int i = 0; i < NT + AW; i++) begin
            @(negedge clk);
            if (i >= AW) check_set(i - AW);
            if (i < NT) drive(sv_vld[i], sv_dst[i], i);
            else idle();
        end

        // R1: latency of a single request, port 2 to port 6
        @(negedge clk);
        dd = '0;
        dd[2] = 3'd6;
        drive(8'h04, dd, 100);
        for (int c = 1; c <= AW; c++) begin
            @(negedge clk);
            if (c == 1) idle();
            check("R1", $sformatf("out_valid[6] after %0d edges", c), out_valid[6], (c == AW));
        end
        check("R1", "payload at port 6", out_data[6*W +: W], pay(100, 2));

        // R3: ports 1 and 3 both to 5, lower source wins
        dd = '0;
        dd[1] = 3'd5;
        dd[3] = 3'd5;
        run_one(8'h0A, dd, 101, ov, od, ob);
        check("R3", "pair 1/3 out_valid", ov, 8'h20);
        check("R3", "pair 1/3 payload", od[5*W +: W], pay(101, 1));
        check("R3", "pair 1/3 blocked", ob, 8'h08);

        // R3: ports 2 and 6 both to 0
        dd = '0;
        run_one(8'h44, dd, 102, ov, od, ob);
        check("R3", "pair 2/6 out_valid", ov, 8'h01);
        check("R3", "pair 2/6 payload", od[W-1:0], pay(102, 2));
        check("R3", "pair 2/6 blocked", ob, 8'h40);

        // R7: invalid switch partner with same destination
        dd = '0;
        dd[0] = 3'd3;
        dd[4] = 3'd3;
        run_one(8'h01, dd, 103, ov, od, ob);
        check("R7", "invalid mate out_valid", ov, 8'h08);
        check("R7", "invalid mate payload", od[3*W +: W], pay(103, 0));
        check("R7", "invalid mate blocked", ob, 8'h00);

        // R8: uniform shift by 5
        for (int s = 0; s < P; s++) dd[s] = AW'((s + 5) % P);
        run_one(8'hFF, dd, 104, ov, od, ob);
        check("R8", "shift 5 out_valid", ov, 8'hFF);
        check("R8", "shift 5 blocked", ob, 8'h00);
        check("R8", "shift 5 port 0 payload", od[W-1:0], pay(104, 3));

        // R6: reset in mid-stream flushes traffic
        for (int s = 0; s < P; s++) dd[s] = AW'(s);
        @(negedge clk);
        drive(8'hFF, dd, 105);
        @(negedge clk);
        drive(8'hFF, dd, 106);
        #2;
        rst_n = 1'b0;
        #1;
        check("R6", "out_valid at mid-stream reset", out_valid, '0);
        check("R6", "out_blocked at mid-stream reset", out_blocked, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        for (int c = 0; c <= AW; c++) begin
            @(negedge clk);
            check("R6", $sformatf("flushed out_valid +%0d", c), out_valid, '0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule